// File: doc/BRIEF.md
# Extended-Precision Power-of-Two Scaler

This unit multiplies an 80-bit extended-precision value by two raised to a signed 32-bit integer. The value has a sign bit, a 15-bit biased exponent and a 64-bit mantissa whose integer bit (bit 63) is explicit. The unit adds the scale straight onto the raw exponent field. When the exponent falls below zero, the mantissa is shifted right with guard and sticky capture and then rounded in one of four modes. When the exponent reaches the top code, an unnormal mantissa is first renormalized, and only then is overflow to infinity decided. A denormal or unnormal that stays in range is normalized only as far as the exponent allows.

A caller supplies the destination value, the integer scale, a class for the scale operand and a rounding mode. It receives the result and a 9-bit flag vector one clock later. Special destinations (zero, infinity, NaN) pass through unchanged and only raise flags. A NaN or infinite scale operand replaces the result with a default NaN.

Top module: `fscale_unit`

## Requirements
- R1: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high, and the result and flags for that operation are held on the outputs in that cycle. Reset clears `out_valid` and `out_flags`. Flag positions: bit0 inexact, bit1 underflow, bit2 overflow, bit3 operand error, bit4 signaling NaN, bit5 NaN, bit6 infinity, bit7 zero, bit8 negative. Every operation computes its flags from scratch.
- R2: For a finite nonzero destination (exponent strictly between 0 and 0x7FFF, or exponent 0 with a nonzero mantissa) whose exponent plus scale lands in 0..0x7FFE and whose integer bit is set, the result keeps the sign and mantissa and carries the exponent plus the scale.
- R3: When exponent plus scale is negative, the result exponent is 0 and the mantissa is shifted right by the deficit. The first bit lost is the guard bit and all later lost bits are sticky. A deficit of 65 or more moves the whole mantissa into sticky. Any nonzero lost bit sets inexact.
- R4: Rounding mode codes are 0 nearest-even, 1 toward zero, 2 toward minus infinity and 3 toward plus infinity. Nearest adds one when the guard bit is set and either a sticky bit or the kept LSB is set. Mode 2 adds one to inexact negatives, mode 3 adds one to inexact positives, and mode 1 truncates. A carry out of the 64-bit mantissa gives mantissa 0x8000_0000_0000_0000 and exponent 1.
- R5: After underflow handling, underflow is flagged when the exponent is 0 and the integer bit is clear. Zero is also flagged when the mantissa is all zero. An increment that reaches the integer bit leaves underflow clear.
- R6: When exponent plus scale is 0x7FFF or more, the mantissa is shifted left to set the integer bit, lowering the exponent by one per position. If the exponent is still 0x7FFF or more, the result is infinity (exponent 0x7FFF, mantissa 0) with the overflow and infinity flags set.
- R7: When exponent plus scale is in range but the integer bit is clear, the mantissa shifts left only while the exponent stays above 0. Underflow is flagged if the integer bit is still clear afterwards.
- R8: Scale class codes 3 (quiet NaN) and 4 (signaling NaN) produce exponent 0x7FFF with an all-ones mantissa. Code 4 also sets the signaling-NaN flag.
- R9: Scale class code 2 (infinity) produces the same default NaN and sets the operand-error and NaN flags.
- R10: A zero destination sets the zero flag. An infinite destination (exponent 0x7FFF, mantissa 0) sets the infinity flag. Any other exponent-0x7FFF destination sets the NaN flag, and it also sets the signaling-NaN flag when mantissa bit 62 is clear. In all three cases the value passes through unchanged.
- R11: Scale class code 1 (zero) acts as a scale of 0 whatever `in_scale` holds, and code 0 uses `in_scale`. The negative flag always equals the result sign, which is the destination sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| in_sign | input | 1 | Destination sign |
| in_exp | input | 15 | Destination biased exponent |
| in_man | input | 64 | Destination mantissa, bit 63 explicit integer bit |
| in_scale | input | 32 | Signed two's-complement scale |
| in_scale_cls | input | 3 | Scale operand class code |
| in_rnd | input | 2 | Rounding mode code |
| out_valid | output | 1 | Result valid |
| out_sign | output | 1 | Result sign |
| out_exp | output | 15 | Result exponent |
| out_man | output | 64 | Result mantissa |
| out_flags | output | 9 | Status flags |

## Verification
Normal values are scaled up and down within range to confirm that the exponent add leaves the mantissa untouched. Underflow cases use deficits of 1, 3, 64, 65 and the most negative scale, in every rounding mode and with both signs. Exact ties with an even and with an odd kept LSB separate nearest-even from plain round-half-up, and an all-ones mantissa shifted by one position shows the increment reaching the integer bit. Unnormals near the top exponent show that renormalization comes before the overflow decision. Denormals scaled by less than, and by more than, their leading-zero count show how far normalization goes. A long random stream biased toward exponent extremes and saturating scales then checks agreement with a bit-serial reference model.

// File: rtl/fscale_pkg.sv
package fscale_pkg;

  typedef enum logic [2:0] {
    SC_NUM  = 3'd0,
    SC_ZERO = 3'd1,
    SC_INF  = 3'd2,
    SC_QNAN = 3'd3,
    SC_SNAN = 3'd4
  } scale_cls_e;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_DOWN = 2'd2,
    RM_UP   = 2'd3
  } rnd_mode_e;

  localparam int FL_INX   = 0;
  localparam int FL_UNF   = 1;
  localparam int FL_OVF   = 2;
  localparam int FL_OPERR = 3;
  localparam int FL_SNAN  = 4;
  localparam int FL_NAN   = 5;
  localparam int FL_INF   = 6;
  localparam int FL_ZERO  = 7;
  localparam int FL_NEG   = 8;
  localparam int FL_W     = 9;

endpackage

// File: rtl/fscale_lzc.sv
module fscale_lzc #(
  parameter int W = 64,
  localparam int CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);

  // Ascending scan: the highest set bit writes last and wins.
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) cnt_o = CNT_W'(W - 1 - i);
    end
  end

endmodule

// File: rtl/fscale_denorm_round.sv
module fscale_denorm_round
  import fscale_pkg::*;
#(
  parameter int MAN_W = 64,
  localparam int SH_MAX = MAN_W + 1,
  localparam int SH_W = $clog2(SH_MAX + 1)
) (
  input  logic [MAN_W-1:0] man_i,
  input  logic [SH_W-1:0]  shamt_i,
  input  logic             neg_i,
  input  logic [1:0]       mode_i,
  output logic [MAN_W-1:0] man_o,
  output logic             carry_o,
  output logic             inexact_o
);

  localparam int WIDE_W = 2 * MAN_W + 1;

  logic [WIDE_W-1:0] wide;
  logic [MAN_W-1:0]  kept;
  logic              guard, sticky, inc;
  logic [MAN_W:0]    sum;

  // The window holds the mantissa plus one guard position plus MAN_W sticky
  // positions, so a saturated shift never drops a bit off the bottom.
  assign wide   = {man_i, {(MAN_W + 1){1'b0}}} >> shamt_i;
  assign kept   = wide[WIDE_W-1:MAN_W+1];
  assign guard  = wide[MAN_W];
  assign sticky = |wide[MAN_W-1:0];
  assign inexact_o = guard | sticky;

  always_comb begin
    unique case (rnd_mode_e'(mode_i))
      RM_NEAR: inc = guard & (sticky | kept[0]);
      RM_ZERO: inc = 1'b0;
      RM_DOWN: inc = inexact_o & neg_i;
      RM_UP:   inc = inexact_o & ~neg_i;
      default: inc = 1'b0;
    endcase
  end

  assign sum     = {1'b0, kept} + {{MAN_W{1'b0}}, inc};
  assign carry_o = sum[MAN_W];
  assign man_o   = carry_o ? {1'b1, {(MAN_W - 1){1'b0}}} : sum[MAN_W-1:0];

endmodule

// File: rtl/fscale_core.sv
module fscale_core
  import fscale_pkg::*;
#(
  parameter int EXP_W   = 15,
  parameter int MAN_W   = 64,
  parameter int SCALE_W = 32
) (
  input  logic               sign_i,
  input  logic [EXP_W-1:0]   exp_i,
  input  logic [MAN_W-1:0]   man_i,
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [2:0]         cls_i,
  input  logic [1:0]         rnd_i,
  output logic               sign_o,
  output logic [EXP_W-1:0]   exp_o,
  output logic [MAN_W-1:0]   man_o,
  output logic [FL_W-1:0]    flags_o
);

  localparam int WE     = SCALE_W + 2;
  localparam int LZ_W   = $clog2(MAN_W + 1);
  localparam int SH_MAX = MAN_W + 1;
  localparam int SH_W   = $clog2(SH_MAX + 1);
  localparam logic [EXP_W-1:0]     EXP_MAX = {EXP_W{1'b1}};
  localparam logic signed [WE-1:0] EXP_TOP = {{(WE - EXP_W){1'b0}}, {EXP_W{1'b1}}};
  localparam logic [WE-1:0]        SH_CAP  = WE'(SH_MAX);

  logic [SCALE_W-1:0]     scale_eff;
  logic signed [WE-1:0]   sexp, lz_ext, sh_ext, e_norm, exp_ir;
  logic [WE-1:0]          deficit;
  logic [SH_W-1:0]        dsat;
  logic                   under, high;
  logic [LZ_W-1:0]        lz, sh_amt;
  logic [MAN_W-1:0]       man_ls, dr_man;
  logic                   dr_carry, dr_inx;
  logic                   dst_zero, dst_top;

  assign scale_eff = (cls_i == SC_ZERO) ? '0 : scale_i;
  assign sexp = $signed({{(WE - EXP_W){1'b0}}, exp_i})
              + $signed({{(WE - SCALE_W){scale_eff[SCALE_W-1]}}, scale_eff});
  assign under   = sexp[WE-1];
  assign high    = !under && (sexp >= EXP_TOP);
  assign deficit = '0 - sexp;
  assign dsat    = (deficit > SH_CAP) ? SH_W'(SH_MAX) : deficit[SH_W-1:0];

  fscale_lzc #(.W(MAN_W)) i_lzc (
    .vec_i (man_i),
    .cnt_o (lz)
  );

  // One left shifter serves both the pre-overflow renormalization (full
  // leading-zero count) and the in-range case (limited by the exponent).
  assign lz_ext = $signed({{(WE - LZ_W){1'b0}}, lz});
  assign sh_amt = high ? lz : ((sexp < lz_ext) ? sexp[LZ_W-1:0] : lz);
  assign sh_ext = $signed({{(WE - LZ_W){1'b0}}, sh_amt});
  assign man_ls = man_i << sh_amt;
  assign e_norm = sexp - lz_ext;
  assign exp_ir = sexp - sh_ext;

  fscale_denorm_round #(.MAN_W(MAN_W)) i_dr (
    .man_i     (man_i),
    .shamt_i   (dsat),
    .neg_i     (sign_i),
    .mode_i    (rnd_i),
    .man_o     (dr_man),
    .carry_o   (dr_carry),
    .inexact_o (dr_inx)
  );

  assign dst_zero = (exp_i == '0) && (man_i == '0);
  assign dst_top  = (exp_i == EXP_MAX);

  always_comb begin
    sign_o  = sign_i;
    exp_o   = exp_i;
    man_o   = man_i;
    flags_o = '0;
    unique case (cls_i)
      SC_QNAN, SC_SNAN: begin
        exp_o = EXP_MAX;
        man_o = '1;
        flags_o[FL_SNAN] = (cls_i == SC_SNAN);
      end
      SC_INF: begin
        exp_o = EXP_MAX;
        man_o = '1;
        flags_o[FL_OPERR] = 1'b1;
        flags_o[FL_NAN]   = 1'b1;
      end
      default: begin
        if (!dst_zero && !dst_top) begin
          if (under) begin
            exp_o = {{(EXP_W - 1){1'b0}}, dr_carry};
            man_o = dr_man;
            flags_o[FL_INX] = dr_inx;
            if (!dr_carry && !dr_man[MAN_W-1]) begin
              flags_o[FL_UNF]  = 1'b1;
              flags_o[FL_ZERO] = (dr_man == '0);
            end
          end else if (high) begin
            if (e_norm >= EXP_TOP) begin
              exp_o = EXP_MAX;
              man_o = '0;
              flags_o[FL_OVF] = 1'b1;
              flags_o[FL_INF] = 1'b1;
            end else begin
              exp_o = EXP_W'(e_norm);
              man_o = man_ls;
            end
          end else begin
            exp_o = EXP_W'(exp_ir);
            man_o = man_ls;
            flags_o[FL_UNF] = !man_ls[MAN_W-1];
          end
        end else if (dst_zero) begin
          flags_o[FL_ZERO] = 1'b1;
        end else if (man_i == '0) begin
          flags_o[FL_INF] = 1'b1;
        end else begin
          flags_o[FL_NAN]  = 1'b1;
          flags_o[FL_SNAN] = !man_i[MAN_W-2];
        end
      end
    endcase
    flags_o[FL_NEG] = sign_o;
  end

endmodule

// File: rtl/fscale_unit.sv
module fscale_unit
  import fscale_pkg::*;
#(
  parameter int EXP_W   = 15,
  parameter int MAN_W   = 64,
  parameter int SCALE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic               in_sign,
  input  logic [EXP_W-1:0]   in_exp,
  input  logic [MAN_W-1:0]   in_man,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic [2:0]         in_scale_cls,
  input  logic [1:0]         in_rnd,
  output logic               out_valid,
  output logic               out_sign,
  output logic [EXP_W-1:0]   out_exp,
  output logic [MAN_W-1:0]   out_man,
  output logic [FL_W-1:0]    out_flags
);

  logic             c_sign;
  logic [EXP_W-1:0] c_exp;
  logic [MAN_W-1:0] c_man;
  logic [FL_W-1:0]  c_flags;

  fscale_core #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SCALE_W(SCALE_W)) i_core (
    .sign_i  (in_sign),
    .exp_i   (in_exp),
    .man_i   (in_man),
    .scale_i (in_scale),
    .cls_i   (in_scale_cls),
    .rnd_i   (in_rnd),
    .sign_o  (c_sign),
    .exp_o   (c_exp),
    .man_o   (c_man),
    .flags_o (c_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_sign  <= 1'b0;
      out_exp   <= '0;
      out_man   <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_sign  <= c_sign;
        out_exp   <= c_exp;
        out_man   <= c_man;
        out_flags <= c_flags;
      end
    end
  end

endmodule

// File: rtl/fscale_chk.sv
module fscale_chk
  import fscale_pkg::*;
#(
  parameter int EXP_W   = 15,
  parameter int MAN_W   = 64,
  parameter int SCALE_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_sign,
  input logic [EXP_W-1:0]   in_exp,
  input logic [MAN_W-1:0]   in_man,
  input logic [SCALE_W-1:0] in_scale,
  input logic [2:0]         in_scale_cls,
  input logic [1:0]         in_rnd,
  input logic               out_valid,
  input logic               out_sign,
  input logic [EXP_W-1:0]   out_exp,
  input logic [MAN_W-1:0]   out_man,
  input logic [FL_W-1:0]    out_flags
);

  localparam logic [EXP_W-1:0] EXP_MAX = {EXP_W{1'b1}};

  a_r1_valid_next: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r1_idle_next: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  a_r6_ovf_is_inf: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flags[FL_OVF] |-> out_exp == EXP_MAX && out_man == '0);

  a_r5_unf_shape: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flags[FL_UNF] |-> !out_man[MAN_W-1]);

  a_r3_inexact_low_exp: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_flags[FL_INX] |-> out_exp <= EXP_W'(1));

  a_r8_snan_scale: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_scale_cls == 3'd4 |=>
      out_flags[FL_SNAN] && out_exp == EXP_MAX && (&out_man));

  a_r9_inf_scale: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_scale_cls == 3'd2 |=>
      out_flags[FL_OPERR] && out_flags[FL_NAN] && (&out_man));

  a_r10_zero_dst: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_scale_cls <= 3'd1 && in_exp == '0 && in_man == '0 |=>
      out_flags[FL_ZERO] && out_exp == '0 && out_man == '0);

  a_r11_neg_sign: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_flags[FL_NEG] == out_sign && out_sign == $past(in_sign));

endmodule

bind fscale_unit fscale_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W), .SCALE_W(SCALE_W)) i_chk (.*);

// File: tb/test_fscale_unit.sv
module test_fscale_unit;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sign = 1'b0;
  logic [14:0] in_exp = '0;
  logic [63:0] in_man = '0;
  logic [31:0] in_scale = '0;
  logic [2:0]  in_scale_cls = '0;
  logic [1:0]  in_rnd = '0;
  logic        out_valid, out_sign;
  logic [14:0] out_exp;
  logic [63:0] out_man;
  logic [8:0]  out_flags;

  int     n_checks = 0;
  int     n_fails = 0;
  longint cyc = 0;
  bit     done = 1'b0;

  typedef struct {
    logic        sign;
    logic [14:0] exp;
    logic [63:0] man;
    logic [8:0]  flags;
    longint      cyc;
    string       tag;
  } item_t;

  item_t sb[$];

  fscale_unit i_fscale_unit (.*);

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Bit-serial reference written from the requirements.
  function automatic void ref_model(
    input logic s, input logic [14:0] e_in, input logic [63:0] m_in,
    input logic [31:0] sc, input logic [2:0] cls, input logic [1:0] md,
    output logic rs, output logic [14:0] re, output logic [63:0] rm,
    output logic [8:0] rf);
    longint e, d;
    logic [63:0] m;
    bit g, st, up;
    rs = s; re = e_in; rm = m_in; rf = '0;
    if (cls == 3 || cls == 4) begin
      re = 15'h7fff; rm = '1; rf[4] = (cls == 4);
    end else if (cls == 2) begin
      re = 15'h7fff; rm = '1; rf[3] = 1; rf[5] = 1;
    end else if ((e_in != 0 && e_in != 15'h7fff) || (e_in == 0 && m_in != 0)) begin
      e = longint'(e_in) + ((cls == 1) ? 64'sd0 : longint'($signed(sc)));
      m = m_in;
      if (e < 0) begin
        d = -e; if (d > 70) d = 70;
        g = 0; st = 0;
        for (longint k = 0; k < d; k++) begin st = st | g; g = m[0]; m = m >> 1; end
        case (md)
          2'd0: up = g && (st || m[0]);
          2'd1: up = 0;
          2'd2: up = (g || st) && s;
          default: up = (g || st) && !s;
        endcase
        re = 0;
        rf[0] = g || st;
        if (up) begin
          if (m == '1) begin m = 64'h8000_0000_0000_0000; re = 1; end
          else m = m + 1;
        end
        rm = m;
        if (re == 0 && !m[63]) begin rf[1] = 1; rf[7] = (m == 0); end
      end else if (e >= 32'h7fff) begin
        for (int k = 0; k < 64 && !m[63]; k++) begin e = e - 1; m = m << 1; end
        if (e >= 32'h7fff) begin re = 15'h7fff; rm = 0; rf[2] = 1; rf[6] = 1; end
        else begin re = 15'(e); rm = m; end
      end else begin
        for (int k = 0; k < 64 && e > 0 && !m[63]; k++) begin e = e - 1; m = m << 1; end
        re = 15'(e); rm = m; rf[1] = !m[63];
      end
    end else if (e_in == 0) rf[7] = 1;
    else if (m_in == 0) rf[6] = 1;
    else begin rf[5] = 1; rf[4] = !m_in[62]; end
    rf[8] = rs;
  endfunction

  task automatic send(input logic s, input logic [14:0] e, input logic [63:0] m,
                      input logic [31:0] sc, input logic [2:0] cls,
                      input logic [1:0] md, input string tag);
    item_t it;
    @(negedge clk);
    in_valid = 1; in_sign = s; in_exp = e; in_man = m;
    in_scale = sc; in_scale_cls = cls; in_rnd = md;
    ref_model(s, e, m, sc, cls, md, it.sign, it.exp, it.man, it.flags);
    it.cyc = cyc; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); in_valid = 0; end
  endtask

  // Monitor: pops expected items as results appear.
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst && out_valid) begin
        n_checks++;
        if (sb.size() == 0) begin
          n_fails++;
          $display("FAIL R1: out_valid=1 actual, expected no result pending");
        end else begin
          it = sb.pop_front();
          if (it.cyc + 1 != cyc) begin
            n_fails++;
            $display("FAIL R1: result at cycle %0d actual, expected %0d", cyc, it.cyc + 1);
          end else if (out_sign !== it.sign || out_exp !== it.exp ||
                       out_man !== it.man || out_flags !== it.flags) begin
            n_fails++;
            $display("FAIL %s: actual s=%0b e=%h m=%h f=%b expected s=%0b e=%h m=%h f=%b",
                     it.tag, out_sign, out_exp, out_man, out_flags,
                     it.sign, it.exp, it.man, it.flags);
          end
        end
      end else if (!rst && sb.size() > 0 && sb[0].cyc + 1 <= cyc) begin
        n_checks++; n_fails++;
        it = sb.pop_front();
        $display("FAIL R1: out_valid=0 actual, expected 1 for %s", it.tag);
      end
    end
  end

  initial begin
    #(20 * 200000);
    n_checks++; n_fails++;
    $display("FAIL R1: watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  localparam logic [63:0] ONE = 64'h8000_0000_0000_0000;

  initial begin
    logic [14:0] re;
    logic [63:0] rm;
    logic [31:0] rs;
    repeat (3) @(negedge clk);
    n_checks++;
    if (out_valid !== 1'b0 || out_flags !== '0) begin
      n_fails++;
      $display("FAIL R1: reset v=%0b f=%b actual, expected v=0 f=0", out_valid, out_flags);
    end
    rst = 0;
    idle(2);
    // R2 in-range scaling
    send(0, 15'h3fff, ONE, 32'd5, 0, 0, "R2");
    send(1, 15'h3fff, 64'hC123_4567_89AB_CDEF, -32'sd100, 0, 0, "R2");
    send(0, 15'h0001, ONE, 32'd0, 0, 1, "R2");
    idle(1);
    // R11 zero-class scale ignores in_scale
    send(1, 15'h1234, ONE, 32'd100, 1, 0, "R11");
    send(0, 15'h0000, 64'h0000_0000_0000_0100, 32'd7, 1, 0, "R11");
    // R3/R4 underflow with ties and all modes
    for (int md = 0; md < 4; md++) begin
      send(0, 15'h0001, 64'h8000_0000_0000_000C, -32'sd4, 2'(md), 2'(md), "R4");
      send(0, 15'h0001, 64'h8000_0000_0000_0004, -32'sd4, 0, 2'(md), "R4");
      send(1, 15'h0001, 64'h8000_0000_0000_0005, -32'sd4, 0, 2'(md), "R4");
      send(0, 15'h0001, 64'h8000_0000_0000_0005, -32'sd4, 0, 2'(md), "R4");
      send(1, 15'h0003, ONE, 32'h8000_0000, 0, 2'(md), "R3");
      send(0, 15'h0001, 64'hC000_0000_0000_0000, -32'sd65, 0, 2'(md), "R3");
      send(1, 15'h0001, 64'h8000_0000_0000_0001, -32'sd66, 0, 2'(md), "R3");
    end
    // R5 increment reaching the integer bit, and full underflow to zero
    send(0, 15'h0001, 64'hFFFF_FFFF_FFFF_FFFF, -32'sd2, 0, 0, "R5");
    send(1, 15'h0001, 64'hFFFF_FFFF_FFFF_FFFF, -32'sd2, 0, 2, "R5");
    send(0, 15'h0001, ONE, -32'sd100, 0, 1, "R5");
    send(0, 15'h0002, 64'h0000_0000_0000_0008, -32'sd2, 0, 0, "R5");
    // R6 overflow and renormalization before the decision
    send(0, 15'h7ffe, ONE, 32'd1, 0, 0, "R6");
    send(1, 15'h7ff0, 64'h0000_0001_0000_0000, 32'h20, 0, 0, "R6");
    send(0, 15'h0000, 64'h1, 32'h7fff, 0, 0, "R6");
    send(0, 15'h4000, 64'h1, 32'h7fff_ffff, 0, 3, "R6");
    send(0, 15'h0000, 64'h1, 32'h803e, 0, 0, "R6");
    // R7 in-range normalization limited by exponent
    send(0, 15'h0000, 64'h0000_0000_0000_0100, 32'd10, 0, 0, "R7");
    send(0, 15'h0000, 64'h0000_0000_0000_0100, 32'd60, 0, 0, "R7");
    send(1, 15'h0010, 64'h4000_0000_0000_0000, 32'd0, 0, 0, "R7");
    send(0, 15'h0005, 64'h0, 32'd3, 0, 0, "R7");
    // R8/R9 special scale operands
    send(1, 15'h3fff, ONE, 32'd3, 3, 0, "R8");
    send(0, 15'h0000, 64'h0, 32'd3, 4, 0, "R8");
    send(0, 15'h7fff, 64'h0, 32'd0, 2, 0, "R9");
    send(1, 15'h2000, ONE, 32'd9, 2, 1, "R9");
    // R10 special destinations
    send(1, 15'h0000, 64'h0, 32'd50, 0, 0, "R10");
    send(0, 15'h7fff, 64'h0, -32'sd50, 0, 0, "R10");
    send(0, 15'h7fff, 64'hC000_0000_0000_0000, 32'd1, 0, 0, "R10");
    send(1, 15'h7fff, 64'h8000_0000_0000_0001, 32'd1, 0, 0, "R10");
    idle(3);
    // Random stream against the reference
    for (int i = 0; i < 600; i++) begin
      case ($urandom % 5)
        0: re = 15'h0;
        1: re = 15'(1 + $urandom % 40);
        2: re = 15'(32'h7ffe - $urandom % 40);
        3: re = 15'($urandom);
        default: re = 15'h7fff;
      endcase
      case ($urandom % 4)
        0: rm = {1'b1, 31'($urandom), 32'($urandom)};
        1: rm = {32'($urandom), 32'($urandom)} >> ($urandom % 64);
        2: rm = '1;
        default: rm = 64'($urandom % 8);
      endcase
      case ($urandom % 5)
        0: rs = 32'($signed(($urandom % 201)) - 100);
        1: rs = -32'(($urandom % 100) + 1);
        2: rs = $urandom;
        3: rs = ($urandom % 2) ? 32'h7fff_ffff : 32'h8000_0000;
        default: rs = 32'(32'h7fff - re + ($urandom % 80) - 40);
      endcase
      send(1'($urandom), re, rm, rs, ($urandom % 8 == 0) ? 3'($urandom % 5) : 3'd0,
           2'($urandom), "R4/R6/R7 random");
      if ($urandom % 6 == 0) idle(1);
    end
    idle(4);
    n_checks++;
    if (sb.size() != 0) begin
      n_fails++;
      $display("FAIL R1: %0d results missing actual, expected 0", sb.size());
    end
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

endmodule